// File: doc/BRIEF.md
# Two-Wire Serial Target with Pointer-Addressed Word Registers

This block is a two-wire (I2C-compatible) serial target that lets an external bus controller read and write a small bank of 16-bit registers. SCL and SDA are sampled by a fast system clock through two-flop synchronizers. Start, repeated-start and stop conditions are found on the synchronized samples. SDA is driven open-drain: the block only ever pulls it low, through an output-enable.

After a start, the controller sends a 7-bit target address and a direction bit. On a write, the first data byte loads an 8-bit pointer. Each later pair of bytes stores one 16-bit word, high byte first, into the register the pointer selects. On a read, the block sends the selected register high byte first and then low byte. It repeats the same register for every word the controller clocks, and it stops at the controller's not-acknowledge. The pointer is kept across transactions, so a read with no pointer write uses the last pointer. The register bank is inside the block, behind a simple one-port read/write interface.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset, `sda_oe` is 0, the pointer is 0 and every register holds 16'h0000.
- R2: The block acknowledges (pulls SDA low through the SCL high phase of the ninth clock) only when the first seven bits after a start equal parameter `TADDR`, sent MSB first. A non-matching address gets no acknowledge. SDA is then never driven, and no pointer or register changes until the next start.
- R3: A write transaction that holds only the pointer byte after the address changes the pointer and leaves every register unchanged.
- R4: In a write, every byte received after a matching address is acknowledged. The bytes after the pointer store words: the first byte of each pair is bits 15:8 and the second is bits 7:0. Each completed pair overwrites the selected register, so the last complete pair wins.
- R5: A read sends bits 15:8 and then bits 7:0 of the selected register, each MSB first. The same register is sent again for every further word, with no pointer increment.
- R6: A read with no pointer write in the same transaction uses the pointer left by the most recent pointer write, or 0 after reset.
- R7: On a read, a not-acknowledge (SDA high in the ninth clock) from the controller ends the transfer. After that the block releases SDA and does not drive it again until the next start.
- R8: `sda_oe` changes only while SCL is low.
- R9: A repeated start after the pointer byte, followed by the matching address with the read bit (bit value 1), returns the register just selected.
- R10: A pointer value of `NREG` or above selects no register. Words written there are acknowledged but discarded, and reads return 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
On the SCL falling edge that ends the low byte of a word, the register write and the start of the acknowledge happen in the same system cycle. Likewise, on the falling edge that ends the address acknowledge of a read, releasing that acknowledge and driving the first data bit happen together. The bench provokes both by writing a word into every register and then reading each one straight back through a repeated start. It also writes two words in one transaction and reads three words in one. It judges the result from the acknowledge bits it samples and from the read-back values it computes from its own model of the bank. A monitor counts any change of `sda_oe` while SCL is high.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKA,
    ST_WR,
    ST_ACKW,
    ST_RD,
    ST_ACKR
  } tgt_state_e;
endpackage

// File: rtl/i2c_ptr_cond.sv
module i2c_ptr_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] scl_sh_q, sda_sh_q;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
    end else begin
      scl_sh_q <= {scl_sh_q[SH_W-2:0], scl_i};
      sda_sh_q <= {sda_sh_q[SH_W-2:0], sda_i};
    end
  end

  assign scl_lvl   = scl_sh_q[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh_q[SYNC_STAGES-1];
  assign scl_prev  = scl_sh_q[SYNC_STAGES];
  assign sda_prev  = sda_sh_q[SYNC_STAGES];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & ~sda_lvl & sda_prev;
  assign stop_det  = scl_lvl & scl_prev & sda_lvl & ~sda_prev;
endmodule

// File: rtl/i2c_ptr_regs.sv
module i2c_ptr_regs #(
  parameter int NREG  = 4,
  parameter int PTR_W = 8,
  parameter int DAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] ptr,
  input  logic [DAT_W-1:0] wr_data,
  output logic [DAT_W-1:0] rd_data
);
  logic [DAT_W-1:0] mem_q [NREG];
  logic [NREG-1:0]  hit;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = (ptr == PTR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && hit[i]) mem_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rd_data = mem_q[i];
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R10
endmodule

// File: rtl/i2c_ptr_fsm.sv
module i2c_ptr_fsm
  import i2c_ptr_pkg::*;
#(
  parameter logic [6:0] TADDR = 7'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [WORD_W-1:0] rd_data,
  output logic [BYTE_W-1:0] ptr,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              sda_oe
);
  tgt_state_e        st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, tx_q, tx_d, ptr_q, ptr_d, hi_q, hi_d;
  logic [1:0]        wph_q, wph_d;
  logic              rw_q, rw_d, lo_q, lo_d, nack_q, nack_d, oe_q, oe_d;
  logic [BYTE_W-1:0] nxt_byte;

  assign nxt_byte = lo_q ? rd_data[7:0] : rd_data[15:8];
  assign wr_data  = {hi_q, sh_q};

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; tx_d = tx_q; ptr_d = ptr_q;
    hi_d = hi_q; wph_d = wph_q; rw_d = rw_q; lo_d = lo_q; nack_d = nack_q;
    oe_d = oe_q; wr_en = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (start_det) begin
      st_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_lvl}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = '0;
            if (sh_q[7:1] == TADDR) begin
              st_d = ST_ACKA; rw_d = sh_q[0]; oe_d = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_ACKA: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_d = rd_data[15:8]; lo_d = 1'b1; oe_d = ~rd_data[15]; st_d = ST_RD;
            end else begin
              oe_d = 1'b0; wph_d = 2'd0; st_d = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_lvl}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = '0; oe_d = 1'b1; st_d = ST_ACKW;
            case (wph_q)
              2'd0:    begin ptr_d = sh_q; wph_d = 2'd1; end
              2'd1:    begin hi_d = sh_q; wph_d = 2'd2; end
              default: begin wr_en = 1'b1; wph_d = 2'd1; end
            endcase
          end
        end
        ST_ACKW: begin
          if (scl_fall) begin
            oe_d = 1'b0; st_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              cnt_d = '0; oe_d = 1'b0; st_d = ST_ACKR;
            end else begin
              tx_d = {tx_q[6:0], 1'b0}; oe_d = ~tx_q[6];
            end
          end
        end
        ST_ACKR: begin
          if (scl_rise) begin
            nack_d = sda_lvl;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_d = ST_IDLE; oe_d = 1'b0;
            end else begin
              tx_d = nxt_byte; lo_d = ~lo_q; oe_d = ~nxt_byte[7]; st_d = ST_RD;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0; ptr_q <= '0;
      hi_q <= '0; wph_q <= '0; rw_q <= 1'b0; lo_q <= 1'b0; nack_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; tx_q <= tx_d; ptr_q <= ptr_d;
      hi_q <= hi_d; wph_q <= wph_d; rw_q <= rw_d; lo_q <= lo_d; nack_q <= nack_d;
      oe_q <= oe_d;
    end
  end

  assign ptr    = ptr_q;
  assign sda_oe = oe_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_lvl); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q); // R7
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACKA || st_q == ST_ACKW) |-> oe_q); // R4
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (oe_q && st_q == ST_ACKW)); // R4
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st_q == ST_ADDR && cnt_q == 4'd0)); // R9
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_ptr_pkg::*;
#(
  parameter logic [6:0] TADDR       = 7'h48,
  parameter int         NREG        = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [BYTE_W-1:0] ptr;
  logic [WORD_W-1:0] wr_data, rd_data;

  i2c_ptr_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ptr_regs #(.NREG(NREG), .PTR_W(BYTE_W), .DAT_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .ptr(ptr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  i2c_ptr_fsm #(.TADDR(TADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n_int), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );
endmodule

// File: tb/i2c_ptr_target_test.sv
`timescale 1ns/1ps
module i2c_ptr_target_test;
  localparam logic [6:0] ADR = 7'h48;
  localparam int NR = 4;
  localparam int H  = 8;
  localparam int Q  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, oe_hi_viol = 0, oe_seen = 0;
  logic oe_prev = 1'b0;
  bit done = 0;
  logic [15:0] model [NR];

  always #2.5 clk = ~clk;

  i2c_ptr_target #(.TADDR(ADR), .NREG(NR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (scl_m && (sda_oe != oe_prev)) oe_hi_viol++;
    if (sda_oe) oe_seen++;
    oe_prev <= sda_oe;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] val(input int p, input int k);
    return 16'hC0DE ^ 16'(p * 16'h0F1F) ^ 16'(k * 16'h3301);
  endfunction

  task automatic bus_start();
    sda_m = 1; cyc(H); scl_m = 1; cyc(H); sda_m = 0; cyc(H); scl_m = 0; cyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; cyc(H); scl_m = 1; cyc(H); sda_m = 1; cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; cyc(H); scl_m = 1; cyc(H); scl_m = 0; cyc(Q);
    end
    sda_m = 1; cyc(H); scl_m = 1; cyc(Q); ack = ~sda_line; cyc(Q);
    scl_m = 0; cyc(Q);
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit more);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; cyc(H); scl_m = 1; cyc(Q); d[i] = sda_line; cyc(Q);
      scl_m = 0; cyc(Q);
    end
    sda_m = more ? 1'b0 : 1'b1; cyc(H); scl_m = 1; cyc(H); scl_m = 0; cyc(Q);
    sda_m = 1;
  endtask

  // write pointer then nw words into it; returns AND of all acks
  task automatic wr_words(input logic [7:0] p, input int nw, input int k, output logic all_ack);
    logic a;
    bus_start();
    send_byte({ADR, 1'b0}, a); all_ack = a;
    send_byte(p, a); all_ack &= a;
    for (int w = 0; w < nw; w++) begin
      send_byte(val(p, k + w) >> 8, a); all_ack &= a;
      send_byte(val(p, k + w) & 16'hFF, a); all_ack &= a;
    end
    bus_stop();
  endtask

  task automatic rd_words(input string req, input bit with_ptr, input logic [7:0] p,
                          input int nw, input logic [15:0] expv);
    logic a;
    logic [7:0] hb, lb;
    bus_start();
    if (with_ptr) begin
      send_byte({ADR, 1'b0}, a); chk(req, 16'(a), 16'd1);
      send_byte(p, a);           chk(req, 16'(a), 16'd1);
      bus_start();
    end
    send_byte({ADR, 1'b1}, a); chk(req, 16'(a), 16'd1);
    for (int w = 0; w < nw; w++) begin
      recv_byte(hb, 1'b1);
      recv_byte(lb, w != nw - 1);
      chk(req, {hb, lb}, expv);
    end
    bus_stop();
  endtask

  initial begin
    logic ok, a;
    logic [7:0] b;
    cyc(5); rst_n = 1; cyc(10);
    chk("R1 oe after reset", 16'(sda_oe), 16'd0);
    for (int i = 0; i < NR; i++) model[i] = '0;
    // R1 R6: read with no pointer write after reset -> register 0, zero
    rd_words("R1 R6 reset read", 1'b0, 8'd0, 1, 16'h0000);

    // R4: a word into every register, all bytes acked
    for (int p = 0; p < NR; p++) begin
      wr_words(8'(p), 1, 0, ok); model[p] = val(p, 0);
      chk("R4 write acks", 16'(ok), 16'd1);
    end
    // R9 R5: pointer, repeated start, word read of each register
    for (int p = 0; p < NR; p++)
      rd_words("R9 R5 readback", 1'b1, 8'(p), 1, model[p]);

    // R3: pointer-only write
    bus_start(); send_byte({ADR, 1'b0}, a); send_byte(8'd2, ok); bus_stop();
    chk("R3 pointer ack", 16'(ok), 16'd1);
    // R5 R6 R3: 3 words, no pointer, same register repeated and unchanged
    rd_words("R5 R6 R3 n-word", 1'b0, 8'd0, 3, model[2]);

    // R7: single-byte read with NACK, then no driving until next start
    bus_start(); send_byte({ADR, 1'b1}, a); recv_byte(b, 1'b0);
    chk("R7 single byte", 16'(b), 16'(model[2] >> 8));
    oe_seen = 0;
    send_byte(8'hFF, a);
    chk("R7 released after nack", 16'(oe_seen), 16'd0);
    bus_stop();

    // R2: wrong address, no ack, trailing bytes ignored
    oe_seen = 0;
    bus_start(); send_byte({ADR ^ 7'h01, 1'b0}, a);
    chk("R2 no ack", 16'(a), 16'd0);
    send_byte(8'd1, a); send_byte(8'h12, a); send_byte(8'h34, a); bus_stop();
    chk("R2 never drives", 16'(oe_seen), 16'd0);
    rd_words("R2 pointer kept", 1'b0, 8'd0, 1, model[2]);
    rd_words("R2 reg unchanged", 1'b1, 8'd1, 1, model[1]);

    // R10: out-of-range pointer
    wr_words(8'd9, 1, 5, ok);
    chk("R10 write acked", 16'(ok), 16'd1);
    rd_words("R10 reads zero", 1'b1, 8'd9, 2, 16'h0000);
    for (int p = 0; p < NR; p++)
      rd_words("R10 bank unchanged", 1'b1, 8'(p), 1, model[p]);

    // R4: two words in one transaction, last one wins
    wr_words(8'd0, 2, 7, ok); model[0] = val(0, 8);
    chk("R4 two-word acks", 16'(ok), 16'd1);
    rd_words("R4 last word wins", 1'b1, 8'd0, 2, model[0]);

    chk("R8 oe stable while scl high", 16'(oe_hi_viol), 16'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule